// File: doc/BRIEF.md
# Multichannel Lane Serializer with Alignment Patterns

This block turns one parallel word per channel into one serial lane per channel. It runs on a bit-rate clock that is `WORD_W` times the conversion rate, and each word goes out over `WORD_W` consecutive bit periods. Next to the lanes it drives two forwarded clocks, a bit clock and a frame clock. Both are decoded from the same bit counter that steps the lanes, so a receiver can sample data on both edges of the bit clock and can find word boundaries from the frame clock.

The configuration inputs pick the bit order and the lane content. The content is either the sample data or one of three alignment patterns: an alternating pattern for deskew, a half-zeros/half-ones pattern for frame sync, or a programmable word. All of these are reversed when the order is set to MSB first. A per-channel power-down flag holds a lane at zero. Every input is sampled only at the boundary between words, so a word never mixes two settings or two samples.

Top module: `lane_serializer_top`

## Requirements
- R1: Each word occupies `WORD_W` (12) consecutive bit periods. `frame_clk` is high during bit periods 0..5 and low during 6..11, so its rising edge comes just before bit 0 of each word.
- R2: `bit_clk` toggles every bit period. It is high in even bit periods (0, 2, ...) and low in odd ones.
- R3: With `pattern_sel`=0 (sample data) and `msb_first`=0, bit period k of a channel's lane carries bit k of that channel's sample.
- R4: With `msb_first`=1, bit period k carries bit 11-k of the selected word.
- R5: With `pattern_sel`=1 the word is 0xAAA. Its bit i is i mod 2, so the LSB-first lane starts 0,1,0,1 and the MSB-first lane starts 1,0,1,0.
- R6: With `pattern_sel`=2 the word is 0xFC0. LSB first this sends six 0s and then six 1s; MSB first it sends six 1s and then six 0s.
- R7: With `pattern_sel`=3 the lane sends `custom_word` in every frame, in the selected bit order.
- R8: `sample_bus` is captured only in the last bit period before a word starts (bit 11 of the previous frame). Changes at other times do not affect the word being sent.
- R9: A channel whose `chan_off` bit is 1 at the frame boundary drives 0 for the whole of the next word.
- R10: `pattern_sel`, `msb_first`, `custom_word` and `chan_off` take effect only from the next frame boundary.
- R11: While `rst_n` is low, all lanes, `frame_clk` and `bit_clk` are 0. The first word after reset starts one clock after `rst_n` rises and carries the inputs present at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock (`WORD_W` x conversion rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_bus | input | CHANNELS*WORD_W | Channel c sample in bits [c*WORD_W +: WORD_W] |
| pattern_sel | input | 2 | 0 sample, 1 deskew, 2 sync, 3 custom |
| msb_first | input | 1 | 1 selects MSB-first bit order |
| custom_word | input | WORD_W | Programmable word for pattern 3 |
| chan_off | input | CHANNELS | Per-channel power-down, lane forced to 0 |
| lane_out | output | CHANNELS | One serial data lane per channel |
| bit_clk | output | 1 | Forwarded clock, one edge per bit |
| frame_clk | output | 1 | Forwarded clock at the conversion rate, rises before bit 0 |

## Verification
If the bit counter drifts or wraps at the wrong count, the fault is visible at once: `frame_clk` loses its 6-high/6-low shape and `bit_clk` stops alternating within one word. A load at the wrong time, or a missing reversal, corrupts the next word on every lane. For this reason, each frame changes every input to garbage during the first half of the word and restores it in the second half; this catches loads made away from the boundary. The bench checks every bit of every lane in every frame against words it computes itself. It sweeps all patterns in both bit orders with several power-down masks.

// File: rtl/lane_serializer_pkg.sv
// Shared types for the lane serializer.
// Assumes nothing beyond a 2-bit pattern selector.
package lane_serializer_pkg;
    typedef enum logic [1:0] {
        PAT_SAMPLE = 2'd0,
        PAT_DESKEW = 2'd1,
        PAT_SYNC   = 2'd2,
        PAT_CUSTOM = 2'd3
    } pat_e;
endpackage

// File: rtl/frame_timer.sv
// Counts bit periods within a word and decodes the forwarded clocks.
// Assumes WORD_W is even and at least 2. After reset the count sits on
// the last bit, so the first word loads on the first edge after reset.
module frame_timer #(
    parameter int WORD_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic last_bit,
    output logic frame_clk,
    output logic bit_clk
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W / 2);

    logic [CNT_W-1:0] cnt;

    // Bit counter: wraps to 0 after the last bit of each word.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= LAST;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    // Output decode: frame high in the first half, bit clock high on even bits.
    always_comb begin
        last_bit  = (cnt == LAST);
        frame_clk = rst_n ? (cnt < HALF) : 1'b0;
        bit_clk   = rst_n ? ~cnt[0] : 1'b0;
    end

    assert_frame_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_clk) |-> $past(last_bit));
    assert_frame_low_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        last_bit |-> !frame_clk);
    assert_bit_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (bit_clk != $past(bit_clk)));
endmodule

// File: rtl/word_source.sv
// Picks the word for one lane (sample or pattern) and applies bit order.
// Purely combinational; the caller samples it only at a frame boundary.
module word_source
    import lane_serializer_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic [WORD_W-1:0] sample,
    input  pat_e              pattern,
    input  logic [WORD_W-1:0] custom,
    input  logic              msb_first,
    output logic [WORD_W-1:0] word
);
    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] deskew_w;
    logic [WORD_W-1:0] sync_w;
    logic [WORD_W-1:0] base_w;
    logic [WORD_W-1:0] rev_w;

    // Pattern constants and bit reversal, one bit per generated slice.
    for (genvar i = 0; i < WORD_W; i++) begin : g_bits
        assign deskew_w[i] = (i % 2) == 1;
        assign sync_w[i]   = (i >= HALF);
        assign rev_w[i]    = base_w[WORD_W-1-i];
    end

    // Content selection by pattern code.
    always_comb begin
        unique case (pattern)
            PAT_DESKEW: base_w = deskew_w;
            PAT_SYNC:   base_w = sync_w;
            PAT_CUSTOM: base_w = custom;
            default:    base_w = sample;
        endcase
    end

    // Bit order: the lane always shifts out bit 0 first.
    assign word = msb_first ? rev_w : base_w;
endmodule

// File: rtl/lane_shifter.sv
// One serial lane: loads a word at the frame boundary, then shifts it out
// bit 0 first. A channel flagged off at load time sends all zeros.
module lane_shifter #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              off,
    output logic              lane
);
    logic [WORD_W-1:0] shreg;
    logic              off_q;

    // Shift register: load at boundary, else move one bit toward the lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            off_q <= 1'b0;
        end else if (load) begin
            shreg <= off ? '0 : word;
            off_q <= off;
        end else begin
            shreg <= {1'b0, shreg[WORD_W-1:1]};
        end
    end

    assign lane = shreg[0];

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        off_q |-> (lane == 1'b0));
endmodule

// File: rtl/lane_serializer_top.sv
// Multichannel serializer: one lane per channel plus forwarded bit and
// frame clocks from a shared bit counter. All inputs are sampled only in
// the last bit period of a word. The clock is the bit-rate clock.
module lane_serializer_top
    import lane_serializer_pkg::*;
#(
    parameter int CHANNELS = 8,
    parameter int WORD_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CHANNELS*WORD_W-1:0] sample_bus,
    input  logic [1:0]                 pattern_sel,
    input  logic                       msb_first,
    input  logic [WORD_W-1:0]          custom_word,
    input  logic [CHANNELS-1:0]        chan_off,
    output logic [CHANNELS-1:0]        lane_out,
    output logic                       bit_clk,
    output logic                       frame_clk
);
    logic last_bit;
    pat_e pattern;

    assign pattern = pat_e'(pattern_sel);

    frame_timer #(.WORD_W(WORD_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_bit  (last_bit),
        .frame_clk (frame_clk),
        .bit_clk   (bit_clk)
    );

    // One word source and shifter per channel.
    for (genvar c = 0; c < CHANNELS; c++) begin : g_lane
        logic [WORD_W-1:0] word;

        word_source #(.WORD_W(WORD_W)) src_i (
            .sample    (sample_bus[c*WORD_W +: WORD_W]),
            .pattern   (pattern),
            .custom    (custom_word),
            .msb_first (msb_first),
            .word      (word)
        );

        lane_shifter #(.WORD_W(WORD_W)) shf_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (last_bit),
            .word  (word),
            .off   (chan_off[c]),
            .lane  (lane_out[c])
        );
    end

    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> (lane_out == '0));
endmodule

// File: tb/lane_serializer_tb.sv
// Frame-by-frame sweep: every bit of every lane is checked against words
// computed here from the requirements.
module lane_serializer_top_tb_top;
    localparam int CH = 8;
    localparam int W  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CH*W-1:0] sample_bus = '0;
    logic [1:0]      pattern_sel = '0;
    logic            msb_first = 1'b0;
    logic [W-1:0]    custom_word = '0;
    logic [CH-1:0]   chan_off = '0;
    logic [CH-1:0]   lane_out;
    logic            bit_clk;
    logic            frame_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [CH*W-1:0] p_s;
    logic [1:0]      p_p;
    logic            p_m;
    logic [W-1:0]    p_c;
    logic [CH-1:0]   p_o;

    always #4 clk = ~clk;

    lane_serializer_top #(.CHANNELS(CH), .WORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_bus(sample_bus),
        .pattern_sel(pattern_sel), .msb_first(msb_first),
        .custom_word(custom_word), .chan_off(chan_off),
        .lane_out(lane_out), .bit_clk(bit_clk), .frame_clk(frame_clk));

    function automatic logic [W-1:0] exp_word(logic [W-1:0] s, logic [1:0] p,
                                              logic m, logic [W-1:0] cu);
        logic [W-1:0] b, r;
        for (int i = 0; i < W; i++) begin
            case (p)
                2'd1:    b[i] = (i % 2) == 1;
                2'd2:    b[i] = (i >= W / 2);
                2'd3:    b[i] = cu[i];
                default: b[i] = s[i];
            endcase
        end
        for (int i = 0; i < W; i++) r[i] = b[W-1-i];
        return m ? r : b;
    endfunction

    function automatic string tag_of(logic off, logic [1:0] p, logic m);
        string t;
        if (off)            t = "R9";
        else if (p == 2'd1) t = "R5";
        else if (p == 2'd2) t = "R6";
        else if (p == 2'd3) t = "R7";
        else if (m)         t = "R4";
        else                t = "R3";
        return {t, " R8 R10"};
    endfunction

    task automatic check(string tag, logic act, logic exp, int ch, int k);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s ch=%0d bit=%0d actual=%b expected=%b", tag, ch, k, act, exp);
        end
    endtask

    task automatic drive(logic [CH*W-1:0] s, logic [1:0] p, logic m,
                         logic [W-1:0] cu, logic [CH-1:0] o);
        sample_bus = s; pattern_sel = p; msb_first = m; custom_word = cu; chan_off = o;
    endtask

    // Called at the negedge in bit 0 of a frame; checks that frame against the
    // previously applied inputs, disturbing inputs in the first half (R8 R10).
    task automatic frame_step(logic [CH*W-1:0] s, logic [1:0] p, logic m,
                              logic [W-1:0] cu, logic [CH-1:0] o);
        for (int k = 0; k < W; k++) begin
            check("R1", frame_clk, k < W / 2, -1, k);
            check("R2", bit_clk, (k % 2) == 0, -1, k);
            for (int c = 0; c < CH; c++) begin
                logic e;
                e = p_o[c] ? 1'b0 : exp_word(p_s[c*W +: W], p_p, p_m, p_c)[k];
                check(tag_of(p_o[c], p_p, p_m), lane_out[c], e, c, k);
            end
            if (k == 0) drive(~s, p + 2'd1, ~m, ~cu, ~o);
            if (k == W / 2) drive(s, p, m, cu, o);
            @(negedge clk);
        end
        p_s = s; p_p = p; p_m = m; p_c = cu; p_o = o;
    endtask

    function automatic logic [CH*W-1:0] make_samples(int f);
        logic [CH*W-1:0] v;
        for (int c = 0; c < CH; c++)
            v[c*W +: W] = W'((c * 32'h135 + f * 32'h2B7 + 32'h5A) & 32'hFFF);
        return v;
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [CH*W-1:0] s0;
        drive({CH*W{1'b1}}, 2'd0, 1'b0, '0, '0);
        repeat (3) @(negedge clk);
        // R11: quiet outputs in reset
        checks++;
        if (lane_out !== '0 || frame_clk !== 1'b0 || bit_clk !== 1'b0) begin
            fails++;
            $display("FAIL R11 actual=%b/%b/%b expected=0/0/0", lane_out, frame_clk, bit_clk);
        end
        s0 = make_samples(0);
        drive(s0, 2'd0, 1'b0, 12'h3C5, '0);
        p_s = s0; p_p = 2'd0; p_m = 1'b0; p_c = 12'h3C5; p_o = '0;
        rst_n = 1'b1;
        @(negedge clk); // bit 0 of the first frame (R11)
        frame_step('0, 2'd0, 1'b0, 12'h3C5, '0);
        frame_step({CH*W{1'b1}}, 2'd0, 1'b1, 12'h3C5, 8'h00);
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 2; m++) begin
                for (int f = 1; f <= 4; f++) begin
                    logic [CH-1:0] off;
                    off = (f == 2) ? 8'hA5 : (f == 4) ? 8'h18 : 8'h00;
                    frame_step(make_samples(f + 7 * p + 3 * m), 2'(p), m[0],
                               W'(32'h5A3 + 32'h111 * f), off);
                end
            end
        end
        frame_step('0, 2'd0, 1'b0, '0, 8'hFF);
        frame_step('0, 2'd0, 1'b0, '0, 8'h00);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule